// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves 8-bit channels between serial time-division multiplexed streams. Several input streams arrive in lockstep, framed by a common frame pulse. Each stream carries 32 channels per frame. Every byte that arrives is stored in a two-bank data memory indexed by stream and channel. For each output slot, a connection memory names the input stream and channel whose byte goes out in that slot, or it holds a fixed byte to send instead. Each output slot also has its own drive enable.

Each output slot picks its throughput delay. A variable-delay slot sends the most recent copy of its source byte that is already stored, so latency is as short as the slot order allows. A constant-delay slot always sends the copy stored during the previous frame. Channels of a wideband group then stay together and keep their order. The data memory banks swap at every frame pulse.

A controller programs the connection memory through a one-cycle synchronous write port. The serial clock runs at twice the bit rate, so each bit cell lasts two clocks.

Top module: `tsi_switch`

## Requirements
- R1: While reset is low, and after reset until the first frame pulse, every `sto_oe` bit is low. Reset clears the connection memory, so every output slot stays disabled until it is programmed.
- R2: A frame is 512 clocks long. `fp_n` is low for exactly one clock, the last clock of a frame. The clock after it starts channel 0, and channel c occupies clocks 16c to 16c+15 of the frame.
- R3: Each bit cell lasts two clocks and bytes travel MSB first. Inputs are sampled on the second clock of a cell. An output bit is held steady for its whole cell.
- R4: A write with `cm_we` high stores `cm_wdata` for output stream `cm_addr[6:5]` and channel `cm_addr[4:0]`. The bit fields are: bit 10 enables the output, bit 9 selects message mode, bit 8 selects constant delay, bits 6:5 give the source stream and bits 4:0 the source channel. In message mode, bits 7:0 hold the byte to send. A write takes effect from the next time that slot is loaded.
- R5: When bit 10 of a slot's entry is clear, `sto_oe` of that stream is low and `sto` is low for the whole slot.
- R6: When message mode is set, the slot sends bits 7:0 of its entry, whatever the delay bit says.
- R7: A variable-delay output in channel c takes source channel sc from the same frame when sc < c. Otherwise it takes it from the previous frame.
- R8: A constant-delay output always sends its source byte from the previous frame, whatever the channel order.
- R9: Any input channel can feed any number of output slots at once, on any streams.
- R10: Input channel 31 of a frame reaches a variable-delay output in channel 0 of the next frame, one slot later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, two per bit cell |
| rst_n | input | 1 | Active-low reset |
| fp_n | input | 1 | Active-low frame pulse, last clock of a frame |
| sti | input | 4 | Serial input streams |
| sto | output | 4 | Serial output streams, low while disabled |
| sto_oe | output | 4 | Per-stream drive enable for the current slot; low means the pad floats |
| cm_we | input | 1 | Connection memory write strobe |
| cm_addr | input | 7 | Output stream (6:5) and output channel (4:0) to write |
| cm_wdata | input | 11 | Connection entry: enable, message, constant delay, source or message byte |

## Verification
The assertions assume that, once the first frame pulse has been seen, `fp_n` falls only on the last clock of a 512-clock frame. They also assume that serial inputs change only at bit-cell edges. The bench builds its stimulus from its own frame counter and raises the pulse only at position 511. It changes inputs on falling edges so each cell holds steady across both rising edges. Connection writes are made at arbitrary points in a frame. Expected bytes are judged only on frames loaded entirely after the write.

// File: rtl/tsi_switch.sv
`timescale 1ns/1ps
module tsi_switch #(
  parameter int NIN  = 4,
  parameter int NOUT = 4,
  parameter int NCH  = 32,
  localparam int SW   = $clog2(NIN),
  localparam int OW   = $clog2(NOUT),
  localparam int CW   = $clog2(NCH),
  localparam int CNTW = CW + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_n,
  input  logic [NIN-1:0]   sti,
  output logic [NOUT-1:0]  sto,
  output logic [NOUT-1:0]  sto_oe,
  input  logic             cm_we,
  input  logic [OW+CW-1:0] cm_addr,
  input  logic [10:0]      cm_wdata
);
  localparam int OE_B = 10, MSG_B = 9, CST_B = 8;

  logic [CNTW-1:0] cnt;
  logic            sync, wbank;
  logic [7:0]      ish [NIN];
  logic [10:0]     cm [NOUT*NCH];
  logic [7:0]      dmem [2*NIN*NCH];

  wire [CW-1:0] cur      = cnt[CNTW-1:4];
  wire [CW-1:0] nc       = cur + 1'b1;
  wire          slot_end = sync && (cnt[3:0] == 4'hF);
  wire          ob       = (nc == '0) ? ~wbank : wbank;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; sync <= 1'b0; wbank <= 1'b0;
    end else if (!fp_n) begin
      cnt <= '0; sync <= 1'b1; wbank <= ~wbank;
    end else
      cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      for (int i = 0; i < NIN; i++) ish[i] <= '0;
    else if (cnt[0])
      for (int i = 0; i < NIN; i++) ish[i] <= {ish[i][6:0], sti[i]};

  always_ff @(posedge clk)
    if (slot_end)
      for (int i = 0; i < NIN; i++)
        dmem[{wbank, SW'(i), cur}] <= {ish[i][6:0], sti[i]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      for (int k = 0; k < NOUT*NCH; k++) cm[k] <= '0;
    else if (cm_we)
      cm[cm_addr] <= cm_wdata;

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    logic [7:0] sh;
    logic       oe_q;
    wire [10:0]   ent    = cm[{OW'(j), nc}];
    wire [SW-1:0] ss     = ent[CW+SW-1:CW];
    wire [CW-1:0] sc     = ent[CW-1:0];
    wire          usecur = !ent[CST_B] && (sc < nc);
    wire          bk     = usecur ? ob : ~ob;
    wire          byp    = (bk == wbank) && (sc == cur);
    wire [7:0]    inb    = {ish[ss][6:0], sti[ss]};
    wire [7:0]    pick   = ent[MSG_B] ? ent[7:0] : byp ? inb : dmem[{bk, ss, sc}];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sh <= '0; oe_q <= 1'b0;
      end else if (slot_end) begin
        sh <= pick; oe_q <= ent[OE_B];
      end else if (cnt[0])
        sh <= {sh[6:0], 1'b0};

    assign sto[j]    = sh[7] & oe_q;
    assign sto_oe[j] = oe_q;

    a_r6_msg_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && ent[OE_B] && ent[MSG_B]) |=> sto[j] == $past(ent[7]));
  end

  a_r2_frame_align: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && !fp_n) |-> cnt == CNTW'(NCH*16-1));
  a_r1_quiet_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |-> sto_oe == '0);
  a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && !cnt[0]) |=> $stable(sto));
  a_r5_oe_per_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[3:0] != 4'hF) |=> $stable(sto_oe));
endmodule

// File: tb/tb_tsi_switch.sv
`timescale 1ns/1ps
module tb_tsi_switch;
  logic clk = 0, rst_n = 0, fp_n = 1, cm_we = 0;
  logic [3:0] sti = '0;
  logic [3:0] sto, sto_oe;
  logic [6:0] cm_addr = '0;
  logic [10:0] cm_wdata = '0;

  tsi_switch dut (.clk(clk), .rst_n(rst_n), .fp_n(fp_n), .sti(sti), .sto(sto),
                  .sto_oe(sto_oe), .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata));

  always #2.5 clk = ~clk;

  // row: out stream, out channel, {oe,msg,cst}, data byte, lag (0 same,1 prev,2 msg,3 off)
  localparam int NR = 12;
  localparam logic [19:0] VEC [NR] = '{
    {2'd0, 5'd5,  3'b100, 1'b0, 2'd1, 5'd2,  2'd0},  // R7 earlier source
    {2'd0, 5'd2,  3'b100, 1'b0, 2'd2, 5'd9,  2'd1},  // R7 later source
    {2'd1, 5'd7,  3'b100, 1'b0, 2'd3, 5'd7,  2'd1},  // R7 equal channel
    {2'd1, 5'd0,  3'b100, 1'b0, 2'd0, 5'd31, 2'd1},  // R10 wrap
    {2'd2, 5'd31, 3'b100, 1'b0, 2'd3, 5'd30, 2'd0},  // R2 last slot
    {2'd2, 5'd4,  3'b101, 1'b0, 2'd1, 5'd1,  2'd1},  // R8
    {2'd3, 5'd20, 3'b101, 1'b0, 2'd0, 5'd25, 2'd1},  // R8
    {2'd3, 5'd3,  3'b111, 8'hA5,             2'd2},  // R6
    {2'd2, 5'd10, 3'b001, 1'b0, 2'd1, 5'd3,  2'd3},  // R5
    {2'd0, 5'd6,  3'b100, 1'b0, 2'd1, 5'd2,  2'd0},  // R9 fan-out
    {2'd1, 5'd31, 3'b100, 1'b0, 2'd0, 5'd0,  2'd0},  // R7
    {2'd3, 5'd0,  3'b101, 1'b0, 2'd2, 5'd31, 2'd1}   // R8 wrap
  };

  int checks = 0, errors = 0, tcnt = 400, tframe = 0;
  bit done = 0;
  logic [7:0] cap [4][32];
  logic       capoe [4][32];
  logic [7:0] cbuf [4];

  function automatic logic [7:0] dat(int f, int s, int c);
    return 8'(f*29 + s*71 + c*13 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    logic [7:0] b;
    tcnt = (tcnt + 1) % 512;
    if (tcnt == 0) tframe++;
    fp_n = (tcnt == 511) ? 1'b0 : 1'b1;
    for (int s = 0; s < 4; s++) begin
      b = dat(tframe, s, tcnt/16);
      sti[s] = b[7 - (tcnt%16)/2];
    end
    if (tcnt % 2 == 0) begin
      for (int j = 0; j < 4; j++) begin
        cbuf[j][7 - (tcnt%16)/2] = sto[j];
        if ((tcnt%16) == 0)  capoe[j][tcnt/16] = sto_oe[j];
        if ((tcnt%16) == 14) cap[j][tcnt/16] = cbuf[j];
      end
    end
  end

  task automatic cmw(input logic [6:0] a, input logic [10:0] d);
    @(posedge clk); #1 cm_we = 1; cm_addr = a; cm_wdata = d;
    @(posedge clk); #1 cm_we = 0;
  endtask

  task automatic wait_fs(input int f);
    @(posedge clk);
    while (!(tcnt == 0 && tframe == f)) @(posedge clk);
  endtask

  task automatic check_rows(input int f);
    for (int r = 0; r < NR; r++) begin
      int j, c, lag;
      logic [10:0] e;
      logic [7:0] eb;
      string tag;
      j = VEC[r][19:18]; c = VEC[r][17:13]; e = VEC[r][12:2]; lag = VEC[r][1:0];
      tag = !e[10] ? "R5" : e[9] ? "R6" : e[8] ? "R8" : "R7";
      chk(capoe[j][c] == (lag != 3), tag, capoe[j][c], lag != 3);
      eb = (lag == 3) ? 8'h00 : (lag == 2) ? e[7:0] : dat(f - lag, e[6:5], e[4:0]);
      chk(cap[j][c] == eb, tag, cap[j][c], eb);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 60000, 0);
      summary();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 chk(sto_oe == 4'h0, "R1 in reset", sto_oe, 0);
    rst_n = 1;
    for (int r = 0; r < NR; r++) cmw({VEC[r][19:18], VEC[r][17:13]}, VEC[r][12:2]);
    @(posedge clk); #1 chk(sto_oe == 4'h0, "R1 before frame pulse", sto_oe, 0);
    for (int f = 3; f <= 4; f++) begin
      wait_fs(f + 1);
      check_rows(f);
      chk(capoe[0][1] == 1'b0, "R1 unprogrammed slot", capoe[0][1], 0);
    end
    // frame 4 captures still held here
    chk(cap[1][0] == dat(3, 0, 31), "R10 wrap variable", cap[1][0], dat(3, 0, 31));
    chk(cap[2][31] == dat(4, 3, 30), "R2 last slot", cap[2][31], dat(4, 3, 30));
    chk(cap[0][5] == cap[0][6] && cap[0][5] == dat(4, 1, 2), "R9 fan-out",
        cap[0][6], dat(4, 1, 2));
    chk(cap[3][3][7] == 1'b1 && cap[3][3][0] == 1'b1, "R3 msb first", cap[3][3], 8'hA5);
    cmw({2'd0, 5'd5}, {3'b110, 8'h3C});
    cmw({2'd0, 5'd6}, {3'b000, 1'b0, 2'd1, 5'd2});
    wait_fs(7);
    chk(cap[0][5] == 8'h3C, "R4 rewrite to message", cap[0][5], 8'h3C);
    chk(capoe[0][6] == 1'b0, "R4 rewrite to disabled", capoe[0][6], 0);
    chk(cap[0][6] == 8'h00, "R5 disabled slot low", cap[0][6], 0);
    chk(cap[1][7] == dat(5, 3, 7), "R7 unaffected slot", cap[1][7], dat(5, 3, 7));
    done = 1;
    summary();
  end
endmodule